// File: doc/BRIEF.md
# Instruction Buffer Purge Sequencer

This block runs the user-level operation that makes a program's own code writes visible to instruction fetch. When decode hands it a purge request with the program counter and length of the purge instruction, the sequencer first waits until every store this processor has already sent to the bus has been seen by the instruction cache's snoop port. Then it flushes the prefetch queue and the younger pipeline stages for one cycle. In the next cycle it steers fetch to the instruction that follows the purge. The instruction cache keeps its lines: snooping has already invalidated any stale ones. The operation has no privilege check, so it raises no fault in user mode.

A small up/down counter follows the stores in flight. A bus store issue counts it up and a snoop completion counts it down. The sequencer compares the counter's next value with zero, so it leaves the wait state at the same edge that takes in the last snoop completion. Decode is held off for the whole time the sequencer is not idle.

Top module: `ibp_purge_ctrl`

## Requirements
- R1: After reset, `busy`, `decode_stall`, `pq_flush`, `pipe_flush` and `redirect_valid` are all low.
- R2: The pending-store count rises by one on `store_issue` and falls by one on `snoop_done`. Both together leave it unchanged. A `snoop_done` while the count is zero is ignored, so a purge taken afterwards still flushes in the cycle after it is sampled.
- R3: A `purge_req` is taken only while the sequencer is idle. A request sampled while `busy` is high starts nothing and leaves the redirect target unchanged.
- R4: No flush happens while stores are pending. A store issued in the same cycle as the purge counts as pending. Flush is asserted in the cycle after the edge at which the pending count reaches zero.
- R5: If the count is zero and no store is issued when a purge is sampled at an edge, `pq_flush` and `pipe_flush` are high in the very next cycle, with no wait cycles.
- R6: `pq_flush` and `pipe_flush` are high together for exactly one cycle per purge.
- R7: `redirect_valid` is high for exactly the one cycle after the flush cycle, and `redirect_pc` then equals `purge_pc + purge_len` modulo 2^ADDR_W.
- R8: `busy` and `decode_stall` are high from the cycle after a purge is taken through the redirect cycle, and low in the cycle after the redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| purge_req | input | 1 | Decode presents a purge instruction |
| purge_pc | input | ADDR_W | Address of the purge instruction |
| purge_len | input | LEN_W | Length of the purge instruction in bytes |
| store_issue | input | 1 | A store from this processor is issued to the bus |
| snoop_done | input | 1 | The instruction cache has snooped one of this processor's stores |
| busy | output | 1 | Sequencer is not idle |
| decode_stall | output | 1 | Hold decode |
| pq_flush | output | 1 | Flush the prefetch queue |
| pipe_flush | output | 1 | Flush pipeline stages younger than the purge |
| redirect_valid | output | 1 | Restart fetch at `redirect_pc` |
| redirect_pc | output | ADDR_W | Fetch restart address |

## Verification
Directed sequences separate the zero-wait path (purge with no stores in flight) from the waiting path (three stores outstanding, drained one snoop at a time). The bench checks the flush cycle against the edge of the last snoop completion. A repeated request during a wait shows whether a busy sequencer wrongly takes a new target. A lone snoop completion at zero, and a store issued together with a snoop completion, show whether the counter underflows or miscounts. A long random phase mixes stores, snoops and purge requests in all states, including stores issued in the same cycle as a purge, and compares every output against a reference model in the bench.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WAIT  = 2'd1,
        PS_FLUSH = 2'd2,
        PS_REDIR = 2'd3
    } purge_state_e;
endpackage

// File: rtl/ibp_store_tracker.sv
module ibp_store_tracker #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_issue,
    input  logic             snoop_done,
    output logic [CNT_W-1:0] cnt_o,
    output logic             drained_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (store_issue && !snoop_done && trk_q.cnt != CNT_MAX)
            trk_d.cnt = trk_q.cnt + CNT_ONE;
        else if (snoop_done && !store_issue && trk_q.cnt != '0)
            trk_d.cnt = trk_q.cnt - CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign cnt_o     = trk_q.cnt;
    assign drained_o = (trk_d.cnt == '0);
endmodule

// File: rtl/ibp_seq_fsm.sv
module ibp_seq_fsm
    import ibp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic purge_req,
    input  logic drained,
    output logic accept_o,
    output logic busy_o,
    output logic flush_o,
    output logic redir_o
);
    typedef struct packed {
        purge_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        accept_o = 1'b0;
        unique case (fsm_q.st)
            PS_IDLE: begin
                if (purge_req) begin
                    accept_o  = 1'b1;
                    fsm_d.st  = drained ? PS_FLUSH : PS_WAIT;
                end
            end
            PS_WAIT:  if (drained) fsm_d.st = PS_FLUSH;
            PS_FLUSH: fsm_d.st = PS_REDIR;
            PS_REDIR: fsm_d.st = PS_IDLE;
            default:  fsm_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q.st <= PS_IDLE;
        else        fsm_q    <= fsm_d;
    end

    assign busy_o  = (fsm_q.st != PS_IDLE);
    assign flush_o = (fsm_q.st == PS_FLUSH);
    assign redir_o = (fsm_q.st == PS_REDIR);
endmodule

// File: rtl/ibp_target_reg.sv
module ibp_target_reg #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] pc,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] tgt_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] tgt;
    } tgt_t;

    tgt_t tgt_d, tgt_q;

    always_comb begin
        tgt_d = tgt_q;
        if (load) tgt_d.tgt = pc + {{(ADDR_W-LEN_W){1'b0}}, len};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgt_q <= '0;
        else        tgt_q <= tgt_d;
    end

    assign tgt_o = tgt_q.tgt;
endmodule

// File: rtl/ibp_purge_ctrl.sv
module ibp_purge_ctrl #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              purge_req,
    input  logic [ADDR_W-1:0] purge_pc,
    input  logic [LEN_W-1:0]  purge_len,
    input  logic              store_issue,
    input  logic              snoop_done,
    output logic              busy,
    output logic              decode_stall,
    output logic              pq_flush,
    output logic              pipe_flush,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc
);
    logic [CNT_W-1:0] pend_cnt_q;
    logic             drained;
    logic             accept;
    logic             seq_busy;
    logic             seq_flush;
    logic             seq_redir;

    ibp_store_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_issue (store_issue),
        .snoop_done  (snoop_done),
        .cnt_o       (pend_cnt_q),
        .drained_o   (drained)
    );

    ibp_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .purge_req (purge_req),
        .drained   (drained),
        .accept_o  (accept),
        .busy_o    (seq_busy),
        .flush_o   (seq_flush),
        .redir_o   (seq_redir)
    );

    ibp_target_reg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_tgt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .pc    (purge_pc),
        .len   (purge_len),
        .tgt_o (redirect_pc)
    );

    assign busy           = seq_busy;
    assign decode_stall   = seq_busy;
    assign pq_flush       = seq_flush;
    assign pipe_flush     = seq_flush;
    assign redirect_valid = seq_redir;
endmodule

// File: rtl/ibp_purge_chk.sv
module ibp_purge_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              purge_req,
    input logic              store_issue,
    input logic              snoop_done,
    input logic              busy,
    input logic              decode_stall,
    input logic              pq_flush,
    input logic              pipe_flush,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic [CNT_W-1:0]  pend_cnt
);
    // R4
    flush_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pq_flush |-> (pend_cnt == '0));

    // R6
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pq_flush |=> (!pq_flush && !pipe_flush));

    // R7
    redirect_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |=> redirect_valid);

    // R8
    idle_after_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (!busy && !decode_stall));

    // R3
    start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(purge_req));

    // R3
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(redirect_pc));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == '0 && snoop_done && !store_issue) |=> (pend_cnt == '0));

    // R8
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pq_flush && !redirect_valid && !decode_stall));
endmodule

bind ibp_purge_ctrl ibp_purge_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .purge_req      (purge_req),
    .store_issue    (store_issue),
    .snoop_done     (snoop_done),
    .busy           (busy),
    .decode_stall   (decode_stall),
    .pq_flush       (pq_flush),
    .pipe_flush     (pipe_flush),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .pend_cnt       (pend_cnt_q)
);

// File: tb/tb_ibp_purge_ctrl.sv
module tb_ibp_purge_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 4;
    localparam int CNT_W  = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              purge_req = 1'b0;
    logic [ADDR_W-1:0] purge_pc = '0;
    logic [LEN_W-1:0]  purge_len = '0;
    logic              store_issue = 1'b0;
    logic              snoop_done = 1'b0;
    logic              busy, decode_stall, pq_flush, pipe_flush, redirect_valid;
    logic [ADDR_W-1:0] redirect_pc;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference model: 0 idle, 1 wait, 2 flush, 3 redirect
    int                m_st = 0, m_st_n = 0;
    int                m_cnt = 0, m_cnt_n = 0;
    logic [ADDR_W-1:0] m_tgt = '0, m_tgt_n = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibp_purge_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .purge_req(purge_req), .purge_pc(purge_pc),
        .purge_len(purge_len), .store_issue(store_issue), .snoop_done(snoop_done),
        .busy(busy), .decode_stall(decode_stall), .pq_flush(pq_flush),
        .pipe_flush(pipe_flush), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    function automatic int next_cnt(int c, bit iss, bit dn);
        if (iss && !dn && c != CNT_MAX) return c + 1;
        if (dn && !iss && c != 0) return c - 1;
        return c;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_check();
        chk("R8 busy", {63'd0, busy}, {63'd0, m_st != 0});
        chk("R8 decode_stall", {63'd0, decode_stall}, {63'd0, m_st != 0});
        chk("R6 flush", {62'd0, pq_flush, pipe_flush}, (m_st == 2) ? 64'd3 : 64'd0);
        chk("R7 redirect_valid", {63'd0, redirect_valid}, {63'd0, m_st == 3});
        if (m_st == 3) chk("R7 redirect_pc", {32'd0, redirect_pc}, {32'd0, m_tgt});
    endtask

    // drive inputs for one cycle, advance model, check after the edge
    task automatic step(bit rq, logic [ADDR_W-1:0] pc, logic [LEN_W-1:0] ln, bit iss, bit dn);
        purge_req = rq; purge_pc = pc; purge_len = ln; store_issue = iss; snoop_done = dn;
        m_cnt_n = next_cnt(m_cnt, iss, dn);
        m_st_n  = m_st;
        m_tgt_n = m_tgt;
        case (m_st)
            0: if (rq) begin
                   m_tgt_n = pc + {{(ADDR_W-LEN_W){1'b0}}, ln};
                   m_st_n  = (m_cnt_n == 0) ? 2 : 1;
               end
            1: if (m_cnt_n == 0) m_st_n = 2;
            2: m_st_n = 3;
            default: m_st_n = 0;
        endcase
        @(negedge clk);
        m_st = m_st_n; m_cnt = m_cnt_n; m_tgt = m_tgt_n;
        model_check();
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 decode_stall", {63'd0, decode_stall}, 64'd0);
        chk("R1 flushes", {62'd0, pq_flush, pipe_flush}, 64'd0);
        chk("R1 redirect_valid", {63'd0, redirect_valid}, 64'd0);

        // R5 zero-wait purge
        step(1, 32'h100, 4'd4, 0, 0);
        chk("R5 immediate flush", {62'd0, pq_flush, pipe_flush}, 64'd3);
        step(0, 0, 0, 0, 0);
        chk("R7 redirect target", {31'd0, redirect_valid, redirect_pc}, {31'd0, 1'b1, 32'h104});
        step(0, 0, 0, 0, 0);
        chk("R8 idle after redirect", {63'd0, busy}, 64'd0);

        // R4 wait for three pending stores
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        step(1, 32'h200, 4'd2, 0, 0);
        chk("R4 wait no flush", {62'd0, busy, pq_flush}, 64'd2);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        chk("R4 one store still pending", {63'd0, pq_flush}, 64'd0);
        step(0, 0, 0, 0, 1);
        chk("R4 flush after last snoop", {62'd0, pq_flush, pipe_flush}, 64'd3);
        step(0, 0, 0, 0, 0);
        chk("R7 redirect after wait", {32'd0, redirect_pc}, 64'h202);
        step(0, 0, 0, 0, 0);

        // R4 store issued with purge counts as pending
        step(1, 32'h280, 4'd4, 1, 0);
        chk("R4 same-cycle store delays flush", {63'd0, pq_flush}, 64'd0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);

        // R3 request while busy ignored
        step(0, 0, 0, 1, 0);
        step(1, 32'h300, 4'd4, 0, 0);
        step(1, 32'h500, 4'd8, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        chk("R3 first target kept", {31'd0, redirect_valid, redirect_pc}, {31'd0, 1'b1, 32'h304});
        step(0, 0, 0, 0, 0);
        chk("R3 no second sequence", {63'd0, busy}, 64'd0);

        // R2 underflow ignored, simultaneous issue+done
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        step(1, 32'hFFFF_FFFE, 4'd4, 0, 0);
        chk("R2 count stayed zero", {62'd0, pq_flush, pipe_flush}, 64'd3);
        step(0, 0, 0, 0, 0);
        chk("R7 address wraps", {32'd0, redirect_pc}, 64'h2);
        step(0, 0, 0, 0, 0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit rq, iss, dn;
            rq  = ($urandom % 6) == 0;
            iss = ($urandom % 3) == 0;
            dn  = (m_cnt != 0) ? (($urandom % 3) != 0) : (($urandom % 8) == 0);
            step(rq, $urandom, 4'($urandom), iss, dn);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule